// File: doc/BRIEF.md
# DRAM Refresh Pacer with Start-up Sequencing

This block decides when an asynchronous DRAM must be refreshed, and it runs from a free-running system clock. After reset it holds off all refresh traffic for a programmable start-up delay (200 µs at the target clock). It then asks for a fixed burst of initialization refreshes, issued one after another. When the last of them has finished, it reports that the memory is ready for ordinary accesses.

After initialization the block raises a refresh slot at a fixed interval. The interval is about 15.6 µs when the retention-mode input is low, which gives 2048 refreshes per 32 ms. It is about 62.5 µs when the input is high, which gives 2048 refreshes per 128 ms. Slots that the access sequencer cannot serve at once are counted in a backlog. A request stays raised until the sequencer grants it. The sequencer reports completion with a done pulse, and each done retires one backlog entry. Either refresh style the sequencer uses (row-only or column-before-row) counts the same. Driving the strobe pins of the memory is left to the sequencer.

Top module: `refresh_pacer`

## Requirements
- R1: While reset is asserted and right after it, refReq, devReady and backlogErr are all low.
- R2: refReq stays low for the first STARTUP_CYC clock edges after reset release. The first initialization request is visible after edge STARTUP_CYC.
- R3: Exactly INIT_REFRESHES initialization requests are issued. Each one after the first is raised in the cycle after the previous done is accepted.
- R4: devReady rises in the cycle after the done of the last initialization refresh is accepted, and it then stays high until reset.
- R5: A refDone pulse while no granted refresh is in flight is ignored: it neither counts as an initialization refresh nor retires a backlog entry.
- R6: A refGrant pulse while refReq is low is ignored, and it does not block later requests.
- R7: With extRetention low, refresh slots fall every NORM_INTERVAL_CYC cycles. The first slot comes NORM_INTERVAL_CYC cycles after devReady rises. The timing of service does not shift the slot grid.
- R8: With extRetention high, slots fall every EXT_INTERVAL_CYC cycles on the same grid rules.
- R9: A raised refReq stays high until a refGrant is seen with it. It drops in the cycle after that grant.
- R10: Unserved slots accumulate. Each accepted done retires one entry, and refReq is raised again in the cycle after a done while entries remain.
- R11: The backlog holds at most PEND_DEPTH entries. A slot that arrives when the backlog is full sets backlogErr in that cycle and is dropped.
- R12: backlogErr is sticky: once set, only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extRetention | input | 1 | High selects the long refresh interval |
| refGrant | input | 1 | Sequencer accepts the raised refresh request |
| refDone | input | 1 | Sequencer finished the granted refresh |
| refReq | output | 1 | Refresh wanted |
| devReady | output | 1 | Initialization complete; ordinary accesses allowed |
| backlogErr | output | 1 | Sticky flag: a slot was lost to a full backlog |

## Verification
The bench builds the block with a 30-cycle start-up delay, intervals of 20 and 60 cycles, eight initialization refreshes and a backlog depth of 4. With these values every phase, both interval grids and a backlog overflow each fall within a few hundred cycles. The shallow backlog lets the fifth unserved slot reach the overflow path quickly. The bench also holds the exact request cycles of a drained backlog, so the saturating count can be told apart from a wrapping one.

// File: rtl/refresh_pacer_pkg.sv
package refresh_pacer_pkg;

  typedef enum logic [1:0] {
    PH_POWERUP = 2'd0,
    PH_INIT    = 2'd1,
    PH_RUN     = 2'd2
  } pacerPhase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic tmrClear;    // restart the shared timer
    logic useStartup;  // timer compares against the start-up delay
    logic initBump;    // one initialization refresh finished
    logic slotTick;    // periodic slot reached
    logic retire;      // one periodic refresh finished
  } pacerStrobes_t;

endpackage

// File: rtl/refresh_pacer_dp.sv
module refresh_pacer_dp
  import refresh_pacer_pkg::*;
#(
  parameter int STARTUP_CYC       = 20000,
  parameter int NORM_INTERVAL_CYC = 1562,
  parameter int EXT_INTERVAL_CYC  = 6250,
  parameter int INIT_REFRESHES    = 8,
  parameter int PEND_DEPTH        = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          extRetention,
  input  pacerStrobes_t strobes,
  output logic          tmrHit,
  output logic          initLast,
  output logic          pendEmpty,
  output logic          backlogErr
);

  localparam int LONG_IVL = (EXT_INTERVAL_CYC > NORM_INTERVAL_CYC) ? EXT_INTERVAL_CYC
                                                                    : NORM_INTERVAL_CYC;
  localparam int TMR_MAX  = (STARTUP_CYC > LONG_IVL) ? STARTUP_CYC : LONG_IVL;
  localparam int TMR_W    = $clog2(TMR_MAX + 1);
  localparam int INIT_W   = $clog2(INIT_REFRESHES + 1);
  localparam int PEND_W   = $clog2(PEND_DEPTH + 1);

  logic [TMR_W-1:0]  tmrCount;
  logic [TMR_W-1:0]  tmrLimit;
  logic [TMR_W-1:0]  runLimit;
  logic [INIT_W-1:0] initCnt;
  logic [PEND_W-1:0] pendCnt;
  logic              pendFull;
  logic              errFlag;

  // interval selection: a single-mode build needs no mux
  generate
    if (NORM_INTERVAL_CYC == EXT_INTERVAL_CYC) begin : g_oneIvl
      assign runLimit = TMR_W'(NORM_INTERVAL_CYC - 1);
    end else begin : g_twoIvl
      assign runLimit = extRetention ? TMR_W'(EXT_INTERVAL_CYC - 1)
                                     : TMR_W'(NORM_INTERVAL_CYC - 1);
    end
  endgenerate

  assign tmrLimit = strobes.useStartup ? TMR_W'(STARTUP_CYC - 1) : runLimit;
  assign tmrHit   = (tmrCount >= tmrLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCount <= '0;
    end else if (strobes.tmrClear) begin
      tmrCount <= '0;
    end else if (!tmrHit) begin
      tmrCount <= tmrCount + 1'b1;
    end
  end

  // initialization refresh counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initCnt <= '0;
    end else if (strobes.initBump) begin
      initCnt <= initCnt + 1'b1;
    end
  end

  assign initLast = (initCnt == INIT_W'(INIT_REFRESHES - 1));

  // backlog of owed periodic refreshes
  assign pendFull  = (pendCnt == PEND_W'(PEND_DEPTH));
  assign pendEmpty = (pendCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCnt <= '0;
    end else begin
      unique case ({strobes.slotTick, strobes.retire})
        2'b10:   if (!pendFull) pendCnt <= pendCnt + 1'b1;
        2'b01:   pendCnt <= pendCnt - 1'b1;
        default: pendCnt <= pendCnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag <= 1'b0;
    end else if (strobes.slotTick && !strobes.retire && pendFull) begin
      errFlag <= 1'b1;
    end
  end

  assign backlogErr = errFlag;

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R11
  pend_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendCnt <= PEND_W'(PEND_DEPTH));

  // R10
  retire_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.retire |-> !pendEmpty);

  // R3
  init_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    initCnt <= INIT_W'(INIT_REFRESHES));

endmodule

// File: rtl/refresh_pacer_ctrl.sv
module refresh_pacer_ctrl
  import refresh_pacer_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          refGrant,
  input  logic          refDone,
  input  logic          tmrHit,
  input  logic          initLast,
  input  logic          pendEmpty,
  output pacerStrobes_t strobes,
  output logic          refReq,
  output logic          devReady
);

  pacerPhase_e phase, nextPhase;
  logic        inFlight;
  logic        reqInt;
  logic        grantTake;
  logic        doneTake;

  assign grantTake = refGrant && reqInt;
  assign doneTake  = refDone && inFlight;

  always_comb begin
    strobes   = '0;
    nextPhase = phase;
    reqInt    = 1'b0;
    unique case (phase)
      PH_POWERUP: begin
        strobes.useStartup = 1'b1;
        if (tmrHit) begin
          strobes.tmrClear = 1'b1;
          nextPhase        = PH_INIT;
        end
      end
      PH_INIT: begin
        strobes.tmrClear = 1'b1;
        reqInt           = !inFlight;
        if (doneTake) begin
          strobes.initBump = 1'b1;
          if (initLast) nextPhase = PH_RUN;
        end
      end
      PH_RUN: begin
        strobes.slotTick = tmrHit;
        strobes.tmrClear = tmrHit;
        strobes.retire   = doneTake;
        reqInt           = !pendEmpty && !inFlight;
      end
      default: nextPhase = PH_POWERUP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_POWERUP;
    end else begin
      phase <= nextPhase;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFlight <= 1'b0;
    end else if (grantTake) begin
      inFlight <= 1'b1;
    end else if (doneTake) begin
      inFlight <= 1'b0;
    end
  end

  assign refReq   = reqInt;
  assign devReady = (phase == PH_RUN);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && !refGrant) |=> refReq);

  // R9
  req_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && refGrant) |=> !refReq);

  // R4
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    devReady |=> devReady);

  // R2
  powerup_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_POWERUP) |-> !refReq);

endmodule

// File: rtl/refresh_pacer.sv
module refresh_pacer
  import refresh_pacer_pkg::*;
#(
  parameter int STARTUP_CYC       = 20000,
  parameter int NORM_INTERVAL_CYC = 1562,
  parameter int EXT_INTERVAL_CYC  = 6250,
  parameter int INIT_REFRESHES    = 8,
  parameter int PEND_DEPTH        = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic extRetention,
  input  logic refGrant,
  input  logic refDone,
  output logic refReq,
  output logic devReady,
  output logic backlogErr
);

  pacerStrobes_t strobes;
  logic          tmrHit;
  logic          initLast;
  logic          pendEmpty;

  refresh_pacer_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .refGrant  (refGrant),
    .refDone   (refDone),
    .tmrHit    (tmrHit),
    .initLast  (initLast),
    .pendEmpty (pendEmpty),
    .strobes   (strobes),
    .refReq    (refReq),
    .devReady  (devReady)
  );

  refresh_pacer_dp #(
    .STARTUP_CYC       (STARTUP_CYC),
    .NORM_INTERVAL_CYC (NORM_INTERVAL_CYC),
    .EXT_INTERVAL_CYC  (EXT_INTERVAL_CYC),
    .INIT_REFRESHES    (INIT_REFRESHES),
    .PEND_DEPTH        (PEND_DEPTH)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .extRetention (extRetention),
    .strobes      (strobes),
    .tmrHit       (tmrHit),
    .initLast     (initLast),
    .pendEmpty    (pendEmpty),
    .backlogErr   (backlogErr)
  );

endmodule

// File: tb/test_refresh_pacer.sv
module test_refresh_pacer;

  localparam int CLK_PERIOD = 10;
  localparam int SU    = 30;
  localparam int NI    = 20;
  localparam int EI    = 60;
  localparam int NINIT = 8;
  localparam int PD    = 4;
  localparam int WDOG  = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extRetention = 1'b0;
  logic refGrant = 1'b0;
  logic refDone = 1'b0;
  logic refReq, devReady, backlogErr;

  int cyc = 0;
  int wdog = 0;
  int nChecks = 0;
  int nFails = 0;
  int expRise[$];
  logic prevReq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refresh_pacer #(
    .STARTUP_CYC(SU), .NORM_INTERVAL_CYC(NI), .EXT_INTERVAL_CYC(EI),
    .INIT_REFRESHES(NINIT), .PEND_DEPTH(PD)
  ) i_refresh_pacer (
    .clk(clk), .rstN(rstN), .extRetention(extRetention),
    .refGrant(refGrant), .refDone(refDone),
    .refReq(refReq), .devReady(devReady), .backlogErr(backlogErr)
  );

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else cyc <= cyc + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: every rising request is compared against the expected cycle
  always @(negedge clk) begin
    int e;
    if (!rstN) begin
      prevReq = 1'b0;
    end else begin
      if (refReq && !prevReq) begin
        if (expRise.size() == 0) begin
          chk("R6/R5/R9 unexpected request cycle", cyc, -1);
        end else begin
          e = expRise.pop_front();
          chk("R2/R3/R7/R8/R10 request cycle", cyc, e);
        end
      end
      prevReq = refReq;
    end
  end

  always @(posedge clk) begin
    wdog <= wdog + 1;
    if (wdog == WDOG) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", wdog, WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  task automatic waitCyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic waitReq();
    while (!refReq) @(negedge clk);
  endtask

  // grant now, done one cycle later
  task automatic serve();
    refGrant = 1'b1;
    @(negedge clk);
    refGrant = 1'b0;
    refDone  = 1'b1;
    @(negedge clk);
    refDone  = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    refGrant = 1'b0;
    refDone = 1'b0;
    expRise.delete();
    repeat (3) @(negedge clk);
    // R1
    chk("R1 refReq in reset", refReq, 0);
    chk("R1 devReady in reset", devReady, 0);
    chk("R1 backlogErr in reset", backlogErr, 0);
    rstN = 1'b1;
  endtask

  task automatic pushInit();
    for (int i = 0; i < NINIT; i++) expRise.push_back(SU + 2*i);
  endtask

  task automatic initBurst();
    for (int i = 0; i < NINIT; i++) begin
      waitReq();
      // R4
      if (i == NINIT-1) chk("R4 devReady before last init done", devReady, 0);
      serve();
    end
    // R4
    chk("R4 devReady after last init done", devReady, 1);
  endtask

  int rdy;

  initial begin
    // ---------- normal mode, prompt service ----------
    extRetention = 1'b0;
    doReset();
    pushInit();
    rdy = SU + 2*NINIT;
    expRise.push_back(rdy + NI);
    expRise.push_back(rdy + 2*NI);
    expRise.push_back(rdy + 3*NI);
    waitCyc(SU-1);
    chk("R2 quiet during start-up", refReq, 0);
    initBurst();
    chk("R4 ready cycle", cyc, rdy);
    // R6: stray grant with no request
    waitCyc(rdy + 4);
    refGrant = 1'b1;
    @(negedge clk);
    refGrant = 1'b0;
    // R5: stray done with nothing in flight
    waitCyc(rdy + 9);
    refDone = 1'b1;
    @(negedge clk);
    refDone = 1'b0;
    // R9: request held while not granted
    waitCyc(rdy + NI + 4);
    chk("R9 request held until grant", refReq, 1);
    serve();
    chk("R9 request dropped after grant", refReq, 0);
    waitCyc(rdy + 2*NI);
    serve();
    waitCyc(rdy + 3*NI);
    serve();
    waitCyc(rdy + 3*NI + 4);
    chk("R7 all normal-mode requests seen", expRise.size(), 0);
    chk("R4 ready stays high", devReady, 1);

    // ---------- extended mode, stray done inside the init burst ----------
    extRetention = 1'b1;
    doReset();
    expRise.push_back(SU);
    for (int i = 1; i < NINIT; i++) expRise.push_back(SU + 3 + 2*(i-1));
    rdy = SU + 2*NINIT + 1;
    expRise.push_back(rdy + EI);
    expRise.push_back(rdy + 2*EI);
    waitReq();
    refDone = 1'b1;                 // R5: ignored, nothing granted yet
    @(negedge clk);
    refDone = 1'b0;
    serve();
    for (int i = 1; i < NINIT; i++) begin
      waitReq();
      serve();
    end
    chk("R5 ready only after real dones", cyc, rdy);
    chk("R4 ready after init (extended)", devReady, 1);
    waitCyc(rdy + EI);
    serve();
    waitCyc(rdy + 2*EI);
    serve();
    waitCyc(rdy + 2*EI + 3);
    chk("R8 all extended-mode requests seen", expRise.size(), 0);

    // ---------- backlog drained back to back ----------
    extRetention = 1'b0;
    doReset();
    pushInit();
    rdy = SU + 2*NINIT;
    expRise.push_back(rdy + NI);
    expRise.push_back(rdy + 3*NI + 6);
    expRise.push_back(rdy + 3*NI + 8);
    expRise.push_back(rdy + 4*NI);
    initBurst();
    waitCyc(rdy + 3*NI + 4);
    chk("R11 no error with three owed", backlogErr, 0);
    for (int i = 0; i < 3; i++) begin
      waitReq();
      serve();
    end
    chk("R10 backlog drained after three dones", refReq, 0);
    waitCyc(rdy + 4*NI);
    serve();
    waitCyc(rdy + 4*NI + 4);
    chk("R10 all backlog requests seen", expRise.size(), 0);

    // ---------- backlog overflow ----------
    doReset();
    pushInit();
    rdy = SU + 2*NINIT;
    expRise.push_back(rdy + NI);
    for (int i = 0; i < PD-1; i++) expRise.push_back(rdy + 5*NI + 6 + 2*i);
    expRise.push_back(rdy + 6*NI);
    initBurst();
    waitCyc(rdy + 5*NI - 1);
    chk("R11 error low while backlog just full", backlogErr, 0);
    waitCyc(rdy + 5*NI);
    chk("R11 error on slot into full backlog", backlogErr, 1);
    waitCyc(rdy + 5*NI + 4);
    for (int i = 0; i < PD; i++) begin
      waitReq();
      serve();
    end
    @(negedge clk);
    chk("R11 backlog saturated at depth", refReq, 0);
    waitCyc(rdy + 6*NI);
    serve();
    waitCyc(rdy + 6*NI + 4);
    chk("R12 error stays set", backlogErr, 1);
    chk("R11 all overflow-run requests seen", expRise.size(), 0);
    doReset();
    chk("R12 error cleared by reset", backlogErr, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule